// File: doc/BRIEF.md
# Multi-Lane Two-Channel Sample Serializer

This block takes one sample pair from two converter channels (A and B) and spreads it over a bank of CMOS output lanes. Each clock cycle of the block is one period of the output data clock. For every lane the block produces two bits per cycle: one for the rising phase and one for the falling phase. Output cells downstream merge these two bits onto the pin.

Software-static configuration inputs select the following:
- Sample resolution: 8, 10, 12 or 16 bits.
- Number of lanes that carry one word.
- Serialization depth: how many cycles one lane needs to carry its share of the word.
- Edge/lane scheme:
  - two-edge on shared lanes;
  - two-edge with each channel on its own lanes;
  - rising-edge only.
- For the shared-lane two-edge scheme, whether the channels alternate per edge or follow each other in sequence.

The block also drives a two-phase frame marker that shows word alignment and a data-clock enable. A configuration that the lane/serialization rules do not allow raises an error flag and keeps the lanes quiet.

The configuration and a new sample pair are taken only at a word boundary. A word boundary is any idle cycle or the last cycle of the word in flight. A sample strobe given at a boundary starts the next word in the following cycle, so words can run back to back.

Top module: `lane_serializer`

## Requirements
- R1: While reset is applied, and right after it, the outputs are as follows: every lane bit is 0, both frame phases are 0, `dclk_en` is 0 and `cfg_err` is 0. The latched configuration resets to 10-bit resolution, one lane per bit, serialization 1, two-edge shared-lane mode with per-edge alternation.
- R2: Resolution code `cfg_res` 0/1/2/3 selects 8/10/12/16 bits, and only the low bits of each channel word are used. With lane code `cfg_lanes`=3 and serialization code `cfg_ser`=0 (depth 1), each bit of the word has its own lane. Lane L carries word bit (resolution-1-L), the word lasts one cycle, and in mode `cfg_mode`=0 the rising bit is from channel A and the falling bit is from channel B.
- R3: At 16-bit resolution, lane code 2/1/0 (8/4/2 lanes) pairs with `cfg_ser` 1/2/3 (depth 2/4/8). The word lasts as many cycles as the depth. Lane 0 holds the most-significant slice, and each lane sends its slice most-significant bit first.
- R4: With `cfg_mode`=0 and `cfg_seq`=1, the 2×depth phases of a word on one lane (rising then falling, cycle by cycle) first carry that lane's channel-A slice, then its channel-B slice.
- R5: With `cfg_mode`=1, channel A uses lanes 0..P-1 and channel B uses lanes P..2P-1, where P is the lane count. Each lane repeats its bit in both phases, and the word lasts depth cycles.
- R6: With `cfg_mode`=2, a word lasts twice the depth in cycles. The rising bits carry the channel-A slice and then the channel-B slice, and every falling bit is 0.
- R7: Take a word of N cycles, counted as 2N phases. The frame marker is high for the first N phases and low for the last N. It is high in the rising phase of the first cycle and low in the falling phase of the last cycle.
- R8: Some combinations are illegal: a 16-bit combination other than the three pairs of R3, a non-16-bit combination other than lane code 3 with depth 1, and `cfg_mode`=3. When such a combination is present at a boundary, `cfg_err` is 1 from the next cycle and no word starts. `cfg_err` stays 1 until a boundary sees a legal combination.
- R9: A strobe, data or configuration change in a cycle that is not a word boundary has no effect on the word in flight, on its successor or on `cfg_err`.
- R10: `dclk_en` is 1 exactly in the cycles of a word. Outside them, and on lanes the mode does not use, all lane bits and frame phases are 0.
- R11: A strobe seen at a boundary with a legal configuration starts the word in the very next cycle, so words can run back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data-clock-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample pair strobe, taken at a word boundary |
| chan_a | input | 16 | Channel A sample (low bits used) |
| chan_b | input | 16 | Channel B sample (low bits used) |
| cfg_res | input | 2 | Resolution code: 0=8, 1=10, 2=12, 3=16 bits |
| cfg_lanes | input | 2 | Lanes per word: 0=2, 1=4, 2=8, 3=one per bit |
| cfg_ser | input | 2 | Serialization depth: 0=1, 1=2, 2=4, 3=8 |
| cfg_mode | input | 2 | 0=two-edge shared, 1=two-edge split lanes, 2=rising only, 3=illegal |
| cfg_seq | input | 1 | Shared two-edge ordering: 0=alternate per edge, 1=A then B |
| lane_rise | output | 32 | Per-lane rising-phase bit |
| lane_fall | output | 32 | Per-lane falling-phase bit |
| frm_rise | output | 1 | Frame marker, rising phase |
| frm_fall | output | 1 | Frame marker, falling phase |
| dclk_en | output | 1 | High while a word is being sent |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The word cycle counter, the latched configuration and the held sample pair are the internal states that matter. A wrong value in the counter shows at the lanes in the same cycle: as a bit from the wrong slice, or as a frame marker that drops too early or too late. A wrong counter also moves the next boundary, so every later word shifts by a cycle, and the cycle-by-cycle scoreboard sees that at once. A configuration latched mid-word, or an error flag updated from a non-boundary cycle, shows up in the first cycle after the corrupted boundary. It appears as a changed lane map, a changed word length, or a `cfg_err` value that differs from the expected one.

// File: rtl/lser_pkg.sv
`timescale 1ns/1ps
package lser_pkg;
   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      IF_DDR  = 2'd0,
      IF_HDDR = 2'd1,
      IF_SDR  = 2'd2,
      IF_BAD  = 2'd3
   } if_mode_e;

   localparam logic [1:0] RES_10     = 2'd1;
   localparam logic [1:0] RES_16     = 2'd3;
   localparam logic [1:0] LANES_FULL = 2'd3;

   typedef struct packed {
      logic [1:0] res;
      logic [1:0] lanes;
      logic [1:0] ser;
      if_mode_e   mode;
      logic       seq;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{res: RES_10, lanes: LANES_FULL, ser: 2'd0,
                                  mode: IF_DDR, seq: 1'b0};

   // legality of a lane/serialization/resolution/mode combination
   function automatic logic cfg_legal(cfg_t c);
      logic pair_ok;
      if (c.res != RES_16)
         pair_ok = (c.ser == 2'd0) && (c.lanes == LANES_FULL);
      else
         pair_ok = ((c.lanes == 2'd2) && (c.ser == 2'd1)) ||
                   ((c.lanes == 2'd1) && (c.ser == 2'd2)) ||
                   ((c.lanes == 2'd0) && (c.ser == 2'd3));
      return pair_ok && (c.mode != IF_BAD);
   endfunction

   // bit at position j counted from the MSB of a left-justified word
   function automatic logic msb_pick(logic [WORD_W-1:0] w, int j);
      logic [WORD_W-1:0] t;
      if (j < 0) return 1'b0;
      t = w << j;
      return t[WORD_W-1];
   endfunction
endpackage

// File: rtl/lser_cfg_decode.sv
`timescale 1ns/1ps
module lser_cfg_decode
   import lser_pkg::*;
#(
   parameter int MAX_SER = 8,
   parameter int CNT_W   = $clog2(2*MAX_SER)
) (
   input  cfg_t             cfg,
   output logic [4:0]       res_w,
   output logic [3:0]       ser_n,
   output logic [5:0]       lanes_n,
   output logic [CNT_W:0]   period,
   output logic [CNT_W-1:0] last_idx
);
   always_comb begin
      case (cfg.res)
         2'd0:    res_w = 5'd8;
         2'd1:    res_w = 5'd10;
         2'd2:    res_w = 5'd12;
         default: res_w = 5'd16;
      endcase
      ser_n = 4'd1 << cfg.ser;
      case (cfg.lanes)
         2'd0:    lanes_n = 6'd2;
         2'd1:    lanes_n = 6'd4;
         2'd2:    lanes_n = 6'd8;
         default: lanes_n = {1'b0, res_w};
      endcase
      if (cfg.mode == IF_SDR)
         period = (CNT_W+1)'({ser_n, 1'b0});
      else
         period = (CNT_W+1)'(ser_n);
      last_idx = CNT_W'(period - 1'b1);
   end
endmodule

// File: rtl/lser_word_ctrl.sv
`timescale 1ns/1ps
module lser_word_ctrl
   import lser_pkg::*;
#(
   parameter int MAX_SER = 8,
   parameter int CNT_W   = $clog2(2*MAX_SER)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [WORD_W-1:0] a_in,
   input  logic [WORD_W-1:0] b_in,
   input  cfg_t              cfg_in,
   input  logic [CNT_W-1:0]  last_idx,
   output logic              active,
   output logic [CNT_W-1:0]  cnt,
   output cfg_t              cfg_q,
   output logic              err_q,
   output logic [WORD_W-1:0] a_q,
   output logic [WORD_W-1:0] b_q,
   output logic              word_last
);
   logic boundary;
   logic in_ok;

   assign word_last = active && (cnt == last_idx);
   assign boundary  = !active || word_last;
   assign in_ok     = cfg_legal(cfg_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         cfg_q  <= CFG_RESET;
         err_q  <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
      end else if (boundary) begin
         cfg_q <= cfg_in;
         err_q <= !in_ok;
         cnt   <= '0;
         if (smp_vld && in_ok) begin
            active <= 1'b1;
            a_q    <= a_in;
            b_q    <= b_in;
         end else begin
            active <= 1'b0;
         end
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/lser_lane_map.sv
`timescale 1ns/1ps
module lser_lane_map
   import lser_pkg::*;
#(
   parameter int LANE_CNT = 32,
   parameter int CNT_W    = 4
) (
   input  logic                active,
   input  logic [CNT_W-1:0]    cnt,
   input  if_mode_e            mode,
   input  logic                seq,
   input  logic [4:0]          res_w,
   input  logic [3:0]          ser_n,
   input  logic [5:0]          lanes_n,
   input  logic [WORD_W-1:0]   a_q,
   input  logic [WORD_W-1:0]   b_q,
   output logic [LANE_CNT-1:0] rise_o,
   output logic [LANE_CNT-1:0] fall_o
);
   logic [WORD_W-1:0] aj;
   logic [WORD_W-1:0] bj;

   // left-justify so that position 0 is always the word MSB
   assign aj = a_q << (WORD_W - int'(res_w));
   assign bj = b_q << (WORD_W - int'(res_w));

   for (genvar gl = 0; gl < LANE_CNT; gl++) begin : g_lane
      always_comb begin
         int k, s, p, base, ph;
         k    = int'(cnt);
         s    = int'(ser_n);
         p    = int'(lanes_n);
         base = gl * s;
         rise_o[gl] = 1'b0;
         fall_o[gl] = 1'b0;
         if (active) begin
            case (mode)
               IF_DDR: if (gl < p) begin
                  if (seq) begin
                     ph = 2 * k;
                     rise_o[gl] = (ph < s) ? msb_pick(aj, base + ph)
                                           : msb_pick(bj, base + ph - s);
                     ph = 2 * k + 1;
                     fall_o[gl] = (ph < s) ? msb_pick(aj, base + ph)
                                           : msb_pick(bj, base + ph - s);
                  end else begin
                     rise_o[gl] = msb_pick(aj, base + k);
                     fall_o[gl] = msb_pick(bj, base + k);
                  end
               end
               IF_HDDR: begin
                  if (gl < p) begin
                     rise_o[gl] = msb_pick(aj, base + k);
                     fall_o[gl] = msb_pick(aj, base + k);
                  end else if (gl < 2 * p) begin
                     rise_o[gl] = msb_pick(bj, (gl - p) * s + k);
                     fall_o[gl] = msb_pick(bj, (gl - p) * s + k);
                  end
               end
               IF_SDR: if (gl < p) begin
                  rise_o[gl] = (k < s) ? msb_pick(aj, base + k)
                                       : msb_pick(bj, base + k - s);
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/lane_serializer.sv
`timescale 1ns/1ps
module lane_serializer
   import lser_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int MAX_SER  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  smp_vld,
   input  logic [SAMPLE_W-1:0]   chan_a,
   input  logic [SAMPLE_W-1:0]   chan_b,
   input  logic [1:0]            cfg_res,
   input  logic [1:0]            cfg_lanes,
   input  logic [1:0]            cfg_ser,
   input  logic [1:0]            cfg_mode,
   input  logic                  cfg_seq,
   output logic [2*SAMPLE_W-1:0] lane_rise,
   output logic [2*SAMPLE_W-1:0] lane_fall,
   output logic                  frm_rise,
   output logic                  frm_fall,
   output logic                  dclk_en,
   output logic                  cfg_err
);
   localparam int LANE_CNT = 2 * SAMPLE_W;
   localparam int CNT_W    = $clog2(2 * MAX_SER);

   if (SAMPLE_W != WORD_W) begin : g_chk_width
      $error("lane_serializer: SAMPLE_W must equal the 16-bit code space");
   end
   if (MAX_SER != 8) begin : g_chk_ser
      $error("lane_serializer: MAX_SER must match the 2-bit depth code");
   end

   cfg_t             cfg_in;
   cfg_t             cfg_q;
   logic             active;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_idx;
   logic [CNT_W:0]   period;
   logic [4:0]       res_w;
   logic [3:0]       ser_n;
   logic [5:0]       lanes_n;
   logic [SAMPLE_W-1:0] a_q;
   logic [SAMPLE_W-1:0] b_q;
   logic             word_last;
   logic             err_q;

   assign cfg_in = '{res: cfg_res, lanes: cfg_lanes, ser: cfg_ser,
                     mode: if_mode_e'(cfg_mode), seq: cfg_seq};

   lser_cfg_decode #(.MAX_SER(MAX_SER), .CNT_W(CNT_W)) dec_i (
      .cfg      (cfg_q),
      .res_w    (res_w),
      .ser_n    (ser_n),
      .lanes_n  (lanes_n),
      .period   (period),
      .last_idx (last_idx)
   );

   lser_word_ctrl #(.MAX_SER(MAX_SER), .CNT_W(CNT_W)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_vld   (smp_vld),
      .a_in      (chan_a),
      .b_in      (chan_b),
      .cfg_in    (cfg_in),
      .last_idx  (last_idx),
      .active    (active),
      .cnt       (cnt),
      .cfg_q     (cfg_q),
      .err_q     (err_q),
      .a_q       (a_q),
      .b_q       (b_q),
      .word_last (word_last)
   );

   lser_lane_map #(.LANE_CNT(LANE_CNT), .CNT_W(CNT_W)) map_i (
      .active  (active),
      .cnt     (cnt),
      .mode    (cfg_q.mode),
      .seq     (cfg_q.seq),
      .res_w   (res_w),
      .ser_n   (ser_n),
      .lanes_n (lanes_n),
      .a_q     (a_q),
      .b_q     (b_q),
      .rise_o  (lane_rise),
      .fall_o  (lane_fall)
   );

   // frame marker: first half of the word's 2*period phases
   assign frm_rise = active && ({1'b0, cnt, 1'b0} < {1'b0, period});
   assign frm_fall = active && ({1'b0, cnt, 1'b1} < {1'b0, period});
   assign dclk_en  = active;
   assign cfg_err  = err_q;
endmodule

// File: rtl/lser_checker.sv
`timescale 1ns/1ps
module lser_checker
   import lser_pkg::*;
#(
   parameter int LANE_CNT = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                dclk_en,
   input logic                cfg_err,
   input logic [LANE_CNT-1:0] lane_rise,
   input logic [LANE_CNT-1:0] lane_fall,
   input logic                frm_rise,
   input logic                frm_fall,
   input logic                word_last,
   input cfg_t                cfg_q
);
   assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (lane_rise == '0 && lane_fall == '0 && !dclk_en));

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !dclk_en |-> (lane_rise == '0 && lane_fall == '0 && !frm_rise && !frm_fall));

   assert_sdr_fall_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dclk_en && cfg_q.mode == IF_SDR) |-> (lane_fall == '0));

   assert_frame_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dclk_en) |-> frm_rise);

   assert_frame_next_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (word_last && dclk_en) |=> (dclk_en -> frm_rise));

   assert_frame_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frm_fall |-> frm_rise);

   assert_frame_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      word_last |-> !frm_fall);

   assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dclk_en && !word_last) |=> $stable(cfg_q));
endmodule

bind lane_serializer lser_checker #(.LANE_CNT(LANE_CNT)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .dclk_en   (dclk_en),
   .cfg_err   (cfg_err),
   .lane_rise (lane_rise),
   .lane_fall (lane_fall),
   .frm_rise  (frm_rise),
   .frm_fall  (frm_fall),
   .word_last (word_last),
   .cfg_q     (cfg_q)
);

// File: tb/lane_serializer_tb_top.sv
`timescale 1ns/1ps
module lane_serializer_tb_top;
   typedef struct packed {
      logic [1:0] res;
      logic [1:0] lanes;
      logic [1:0] ser;
      logic [1:0] mode;
      logic       seq;
   } tcfg_t;

   typedef struct {
      logic [31:0] rise;
      logic [31:0] fall;
      logic        fr;
      logic        ff;
      logic        en;
      logic        err;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [15:0] chan_a = '0;
   logic [15:0] chan_b = '0;
   logic [1:0]  cfg_res = 2'd1;
   logic [1:0]  cfg_lanes = 2'd3;
   logic [1:0]  cfg_ser = 2'd0;
   logic [1:0]  cfg_mode = 2'd0;
   logic        cfg_seq = 1'b0;
   logic [31:0] lane_rise, lane_fall;
   logic        frm_rise, frm_fall, dclk_en, cfg_err;

   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;
   exp_t q[$];
   tcfg_t cur_cfg;

   always #10 clk = ~clk;

   lane_serializer dut_i (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
      .chan_a(chan_a), .chan_b(chan_b),
      .cfg_res(cfg_res), .cfg_lanes(cfg_lanes), .cfg_ser(cfg_ser),
      .cfg_mode(cfg_mode), .cfg_seq(cfg_seq),
      .lane_rise(lane_rise), .lane_fall(lane_fall),
      .frm_rise(frm_rise), .frm_fall(frm_fall),
      .dclk_en(dclk_en), .cfg_err(cfg_err)
   );

   function automatic tcfg_t mk(int res, int lanes, int ser, int mode, int seq);
      tcfg_t c;
      c.res = 2'(res); c.lanes = 2'(lanes); c.ser = 2'(ser);
      c.mode = 2'(mode); c.seq = 1'(seq);
      return c;
   endfunction

   function automatic bit is_legal(tcfg_t c);
      if (c.mode == 2'd3) return 1'b0;
      if (c.res == 2'd3)
         return (c.lanes == 2'd2 && c.ser == 2'd1) ||
                (c.lanes == 2'd1 && c.ser == 2'd2) ||
                (c.lanes == 2'd0 && c.ser == 2'd3);
      return c.lanes == 2'd3 && c.ser == 2'd0;
   endfunction

   function automatic int res_bits(tcfg_t c);
      case (c.res)
         2'd0: return 8;
         2'd1: return 10;
         2'd2: return 12;
         default: return 16;
      endcase
   endfunction

   function automatic int word_len(tcfg_t c);
      return (c.mode == 2'd2) ? (2 << c.ser) : (1 << c.ser);
   endfunction

   // j-th bit of an r-bit sample, counted from its MSB
   function automatic logic sbit(logic [15:0] w, int r, int j);
      if (j < 0 || j >= r) return 1'b0;
      return w[r-1-j];
   endfunction

   function automatic exp_t model(tcfg_t c, logic [15:0] a, logic [15:0] b,
                                  int k, string tag);
      exp_t e;
      int r, s, p, n;
      r = res_bits(c);
      s = 1 << c.ser;
      p = (c.lanes == 2'd3) ? r : (2 << c.lanes);
      n = word_len(c);
      e.rise = '0; e.fall = '0;
      for (int l = 0; l < p; l++) begin
         if (c.mode == 2'd0 && c.seq) begin
            // phase order on a lane: A slice phases then B slice phases
            e.rise[l] = (2*k < s) ? sbit(a, r, l*s + 2*k) : sbit(b, r, l*s + 2*k - s);
            e.fall[l] = (2*k+1 < s) ? sbit(a, r, l*s + 2*k + 1)
                                    : sbit(b, r, l*s + 2*k + 1 - s);
         end else if (c.mode == 2'd0) begin
            e.rise[l] = sbit(a, r, l*s + k);
            e.fall[l] = sbit(b, r, l*s + k);
         end else if (c.mode == 2'd1) begin
            e.rise[l]   = sbit(a, r, l*s + k);
            e.fall[l]   = e.rise[l];
            e.rise[l+p] = sbit(b, r, l*s + k);
            e.fall[l+p] = e.rise[l+p];
         end else begin
            e.rise[l] = (k < s) ? sbit(a, r, l*s + k) : sbit(b, r, l*s + k - s);
         end
      end
      e.fr = (2*k < n);
      e.ff = (2*k + 1 < n);
      e.en = 1'b1;
      e.err = 1'b0;
      e.tag = tag;
      return e;
   endfunction

   function automatic exp_t quiet(bit err, string tag);
      exp_t e;
      e.rise = '0; e.fall = '0; e.fr = 1'b0; e.ff = 1'b0;
      e.en = 1'b0; e.err = err; e.tag = tag;
      return e;
   endfunction

   task automatic put_cfg(tcfg_t c);
      cfg_res = c.res; cfg_lanes = c.lanes; cfg_ser = c.ser;
      cfg_mode = c.mode; cfg_seq = c.seq;
   endtask

   // driver: starts a word at a boundary, optionally disturbs non-boundary cycles (R9)
   task automatic send_word(tcfg_t c, logic [15:0] a, logic [15:0] b,
                            string tag, bit disturb);
      int n;
      @(negedge clk);
      put_cfg(c); cur_cfg = c;
      chan_a = a; chan_b = b; smp_vld = 1'b1;
      n = word_len(c);
      for (int k = 0; k < n; k++) q.push_back(model(c, a, b, k, tag));
      for (int i = 1; i < n; i++) begin
         @(negedge clk);
         smp_vld = disturb;
         if (disturb) begin
            chan_a = ~a; chan_b = a ^ b ^ 16'h5a5a;
            cfg_mode = 2'd3; cfg_res = ~c.res; cfg_seq = ~c.seq;
         end
      end
   endtask

   task automatic idle(int cycles, string tag);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         smp_vld = 1'b0; put_cfg(cur_cfg);
         q.push_back(quiet(!is_legal(cur_cfg), tag));
      end
   endtask

   task automatic bad_word(tcfg_t c, string tag);
      @(negedge clk);
      put_cfg(c); cur_cfg = c;
      chan_a = 16'hffff; chan_b = 16'hffff; smp_vld = 1'b1;
      q.push_back(quiet(1'b1, tag));
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // monitor: compares a quarter period after each rising edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            e = q.pop_front();
            total++;
            if (lane_rise !== e.rise || lane_fall !== e.fall || frm_rise !== e.fr ||
                frm_fall !== e.ff || dclk_en !== e.en || cfg_err !== e.err) begin
               bad++;
               $display("FAIL %s act rise=%h fall=%h fr=%b ff=%b en=%b err=%b exp rise=%h fall=%h fr=%b ff=%b en=%b err=%b",
                        e.tag, lane_rise, lane_fall, frm_rise, frm_fall, dclk_en, cfg_err,
                        e.rise, e.fall, e.fr, e.ff, e.en, e.err);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         done = 1'b1;
         summary();
         $finish;
      end
   end

   initial begin
      cur_cfg = mk(1, 3, 0, 0, 0);
      repeat (3) @(negedge clk);
      // R1: outputs quiet under reset
      total++;
      if (lane_rise !== '0 || lane_fall !== '0 || frm_rise || frm_fall || dclk_en || cfg_err) begin
         bad++;
         $display("FAIL R1 reset act rise=%h fall=%h en=%b err=%b exp all zero",
                  lane_rise, lane_fall, dclk_en, cfg_err);
      end
      rst_n = 1'b1;
      idle(2, "R1");

      // R2 / R11: one lane per bit, back to back
      send_word(mk(1, 3, 0, 0, 0), 16'hf2b5, 16'h0139, "R2", 1'b0);
      send_word(mk(1, 3, 0, 0, 0), 16'h0000, 16'h03ff, "R11", 1'b0);
      send_word(mk(0, 3, 0, 0, 0), 16'hab5c, 16'h77c3, "R2", 1'b0);
      send_word(mk(2, 3, 0, 0, 0), 16'h1a5f, 16'hf3c0, "R2", 1'b0);
      idle(2, "R10");

      // R3: 16-bit split over 8/4/2 lanes, with disturbance on non-boundary cycles (R9)
      send_word(mk(3, 2, 1, 0, 0), 16'hc3a5, 16'h5e71, "R3", 1'b0);
      send_word(mk(3, 1, 2, 0, 0), 16'h8001, 16'h7ffe, "R3", 1'b1);
      send_word(mk(3, 0, 3, 0, 0), 16'h9d2c, 16'h46e1, "R9", 1'b1);
      idle(1, "R10");

      // R4: channel-sequential two-edge order
      send_word(mk(3, 1, 2, 0, 1), 16'hb6d3, 16'h2c8f, "R4", 1'b0);
      send_word(mk(3, 0, 3, 0, 1), 16'hf00f, 16'h0ff0, "R4", 1'b1);
      send_word(mk(1, 3, 0, 0, 1), 16'h02aa, 16'h0155, "R4", 1'b0);

      // R5: split lanes per channel
      send_word(mk(3, 2, 1, 1, 0), 16'he41b, 16'h3c96, "R5", 1'b0);
      send_word(mk(2, 3, 0, 1, 0), 16'h0abc, 16'h0543, "R5", 1'b0);
      send_word(mk(3, 0, 3, 1, 0), 16'h1234, 16'hfedc, "R5", 1'b1);

      // R6: rising-only, double-length words
      send_word(mk(3, 0, 3, 2, 0), 16'ha5c3, 16'h3c5a, "R6", 1'b1);
      send_word(mk(0, 3, 0, 2, 0), 16'h00d9, 16'h0026, "R6", 1'b0);
      send_word(mk(3, 2, 1, 2, 0), 16'h6f90, 16'h0b7e, "R7", 1'b0);
      idle(2, "R10");

      // R8: illegal combinations hold the error until a legal boundary
      bad_word(mk(3, 3, 0, 0, 0), "R8");
      idle(3, "R8");
      bad_word(mk(1, 3, 1, 0, 0), "R8");
      bad_word(mk(3, 2, 1, 3, 0), "R8");
      idle(2, "R8");
      send_word(mk(3, 1, 2, 0, 0), 16'h4d2b, 16'hd4b2, "R8", 1'b0);
      idle(2, "R8");

      wait (q.size() == 0);
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         summary();
         $finish;
      end
   end
endmodule